// File: doc/BRIEF.md
# I2C Controller Interrupt Vector Unit

This block gathers the event pulses of an I2C controller into sticky status flags, gates them with a software-written enable mask and reports one pending enabled event as a small numeric code. An interrupt handler reads the vector register in a loop. Each read returns the code of the most urgent pending enabled event, or zero when nothing enabled is pending. Reading a code consumes the event it names. The two data-ready events are the exception: they stay pending until the data register, which lives outside this block, is accessed.

Software reaches the unit through a simple register port with single-cycle read and write strobes. Read data appears one cycle after the read strobe. The level interrupt output is high while any enabled flag is pending. Event detection and the data register belong to the surrounding controller. That controller supplies single-cycle event pulses and single-cycle data-access pulses.

Top module: `i2c_ivu`

## Requirements
- R1: After reset, all event flags, the enable mask, the read data and the interrupt output are zero.
- R2: A pulse on event_i[k] sets status bit k. The bit order is 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. The status register at offset 0x08 also shows rs_full_i live at bit 11 and bus_busy_i live at bit 12. All other bits read 0.
- R3: A write to the status register clears each event flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: The mask register at offset 0x04 is written and read back in bits 6:0, with the same bit order as the status flags. Its upper bits read 0.
- R5: The vector register at offset 0x28 reads 0 when no flag is both pending and enabled.
- R6: Otherwise the vector register returns the code k+1 of the enabled pending flag with the lowest k. Disabled flags are never reported.
- R7: A vector read clears the flag it reports, except for codes 4 (receive ready) and 5 (transmit ready).
- R8: A pulse on rx_data_rd_i clears flag 3, and a pulse on tx_data_wr_i clears flag 4.
- R9: An event pulse arriving in the same cycle as any clear of the same flag leaves that flag set.
- R10: irq_o is high exactly while some flag is both set and enabled. It rises in the cycle after the event pulse.
- R11: rdata_o is loaded on the clock edge that samples rd_en_i and holds its value until the next read. Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| event_i | input | 7 | Event pulses from the controller |
| bus_busy_i | input | 1 | Bus busy level, shown in status |
| rs_full_i | input | 1 | Receive shift register full level, shown in status |
| rx_data_rd_i | input | 1 | Receive data register was read |
| tx_data_wr_i | input | 1 | Transmit data register was written |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that event_i, the data-access pulses and the register strobes are driven synchronously and are at their inactive values at the first clock edge after reset. They also assume that a strobe lasts a single cycle for each intended access. The bench changes every input on the falling edge and deasserts each pulse right after the rising edge that consumes it. Collisions between an event and a clear are created on purpose by driving both in one cycle. The bench never issues a read and a write together.

// File: rtl/i2c_ivu_pkg.sv
package i2c_ivu_pkg;
  localparam int unsigned NUM_EV   = 7;
  localparam int unsigned DW       = 16;
  localparam int unsigned AW       = 8;
  localparam int unsigned CODE_W   = $clog2(NUM_EV + 1);
  localparam int unsigned RX_BIT   = 3;
  localparam int unsigned TX_BIT   = 4;
  localparam int unsigned RSF_BIT  = 11;
  localparam int unsigned BB_BIT   = 12;
  localparam logic [AW-1:0] OFS_MASK = 8'h04;
  localparam logic [AW-1:0] OFS_STAT = 8'h08;
  localparam logic [AW-1:0] OFS_VEC  = 8'h28;
endpackage

// File: rtl/i2c_ivu_flags.sv
module i2c_ivu_flags
  import i2c_ivu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] set_i,
  input  logic [NUM_EV-1:0] clr_i,
  output logic [NUM_EV-1:0] flags_o
);
  for (genvar k = 0; k < NUM_EV; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[k] <= 1'b0;
      else if (set_i[k])  flags_o[k] <= 1'b1;   // set wins over clear
      else if (clr_i[k])  flags_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_ivu_prio.sv
module i2c_ivu_prio
  import i2c_ivu_pkg::*;
(
  input  logic [NUM_EV-1:0] pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic [NUM_EV-1:0] sel_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int k = NUM_EV - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        code_o = CODE_W'(k + 1);
        sel_o  = NUM_EV'(1) << k;
      end
    end
  end
endmodule

// File: rtl/i2c_ivu.sv
module i2c_ivu
  import i2c_ivu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_EV-1:0] event_i,
  input  logic              bus_busy_i,
  input  logic              rs_full_i,
  input  logic              rx_data_rd_i,
  input  logic              tx_data_wr_i,
  output logic              irq_o
);
  localparam logic [NUM_EV-1:0] KEEP_ON_RD = NUM_EV'((1 << RX_BIT) | (1 << TX_BIT));

  logic [NUM_EV-1:0] flags_q, mask_q, pend, sel, clr;
  logic [CODE_W-1:0] code;
  logic [DW-1:0]     stat_word, rd_mux;
  logic              wr_mask, wr_stat, rd_vec;

  assign wr_mask = wr_en_i && (addr_i == OFS_MASK);
  assign wr_stat = wr_en_i && (addr_i == OFS_STAT);
  assign rd_vec  = rd_en_i && (addr_i == OFS_VEC);
  assign pend    = flags_q & mask_q;

  i2c_ivu_prio u_prio (
    .pend_i (pend),
    .code_o (code),
    .sel_o  (sel)
  );

  always_comb begin
    clr = '0;
    if (wr_stat) clr = clr | wdata_i[NUM_EV-1:0];
    if (rd_vec)  clr = clr | (sel & ~KEEP_ON_RD);
    clr[RX_BIT] = clr[RX_BIT] | rx_data_rd_i;
    clr[TX_BIT] = clr[TX_BIT] | tx_data_wr_i;
  end

  i2c_ivu_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (event_i),
    .clr_i   (clr),
    .flags_o (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i[NUM_EV-1:0];
  end

  always_comb begin
    stat_word = '0;
    stat_word[NUM_EV-1:0] = flags_q;
    stat_word[RSF_BIT]    = rs_full_i;
    stat_word[BB_BIT]     = bus_busy_i;
  end

  always_comb begin
    unique case (addr_i)
      OFS_MASK: rd_mux = DW'(mask_q);
      OFS_STAT: rd_mux = stat_word;
      OFS_VEC:  rd_mux = DW'(code);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign irq_o = |pend;
endmodule

// File: rtl/i2c_ivu_chk.sv
module i2c_ivu_chk
  import i2c_ivu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NUM_EV-1:0] event_i,
  input logic [NUM_EV-1:0] flags_q,
  input logic [NUM_EV-1:0] mask_q
);
  a_r2_only_events_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(event_i)) == '0));

  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_STAT) |=>
      ((flags_q & $past(wdata_i[NUM_EV-1:0]) & ~$past(event_i)) == '0));

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & $past(event_i)) == $past(event_i)));

  a_r5_vec_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_VEC && (flags_q & mask_q) == '0) |=> (rdata_o == '0));

  a_r6_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_VEC && (flags_q & mask_q) != '0) |=>
      (rdata_o != '0 && rdata_o <= DW'(NUM_EV)));

  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind i2c_ivu i2c_ivu_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .event_i (event_i),
  .flags_q (flags_q),
  .mask_q  (mask_q)
);

// File: tb/tb_i2c_ivu.sv
module tb_i2c_ivu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [6:0]  event_i = '0;
  logic        bus_busy_i = 1'b0, rs_full_i = 1'b0;
  logic        rx_data_rd_i = 1'b0, tx_data_wr_i = 1'b0;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28, A_NONE = 8'h10;

  always #4 clk_i = ~clk_i;

  i2c_ivu dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive on falling edge, release after rising edge
  task automatic cyc(logic [7:0] a, logic wr, logic rd, logic [15:0] d,
                     logic [6:0] ev, logic rx, logic tx);
    @(negedge clk_i);
    addr_i = a; wr_en_i = wr; rd_en_i = rd; wdata_i = d;
    event_i = ev; rx_data_rd_i = rx; tx_data_wr_i = tx;
    @(posedge clk_i); #1;
    wr_en_i = 0; rd_en_i = 0; event_i = '0; rx_data_rd_i = 0; tx_data_wr_i = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d); cyc(a, 1, 0, d, '0, 0, 0); endtask
  task automatic pulse(logic [6:0] ev); cyc(8'h00, 0, 0, '0, ev, 0, 0); endtask
  task automatic rd_chk(logic [7:0] a, logic [15:0] exp, string req);
    cyc(a, 0, 1, '0, '0, 0, 0);
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata_o, 16'h0);
    chk("R1 irq", 16'(irq_o), 16'h0);
    rd_chk(A_STAT, 16'h0000, "R1 status");
    rd_chk(A_MASK, 16'h0000, "R1 mask");
    rd_chk(A_VEC,  16'h0000, "R1 vector");
  endtask

  task automatic t_status;
    bus_busy_i = 1; rs_full_i = 1;
    pulse(7'h25);
    rd_chk(A_STAT, 16'h1825, "R2 status bits");
    chk("R10 irq masked off", 16'(irq_o), 16'h0);
    rd_chk(A_VEC, 16'h0000, "R5 all masked");
  endtask

  task automatic t_w1c;
    wr(A_STAT, 16'h0001);
    rd_chk(A_STAT, 16'h1824, "R3 clear bit0");
    wr(A_STAT, 16'h0000);
    rd_chk(A_STAT, 16'h1824, "R3 zero write");
    wr(A_STAT, 16'h007f);
    rd_chk(A_STAT, 16'h1800, "R3 clear all");
    bus_busy_i = 0; rs_full_i = 0;
    rd_chk(A_STAT, 16'h0000, "R2 live levels");
  endtask

  task automatic t_mask;
    wr(A_MASK, 16'hffff);
    rd_chk(A_MASK, 16'h007f, "R4 mask width");
    wr(A_MASK, 16'h0012);
    rd_chk(A_MASK, 16'h0012, "R4 mask value");
  endtask

  task automatic t_prio;
    wr(A_MASK, 16'h007f);
    pulse(7'h70);
    chk("R10 irq rise", 16'(irq_o), 16'h1);
    rd_chk(A_VEC, 16'd5, "R6 lowest code");
    rd_chk(A_VEC, 16'd5, "R7 tx kept on read");
    cyc(8'h00, 0, 0, '0, '0, 0, 1);
    rd_chk(A_VEC, 16'd6, "R8 tx access clears");
    rd_chk(A_VEC, 16'd7, "R7 consumed stop");
    rd_chk(A_VEC, 16'd0, "R5 drained");
    chk("R10 irq fall", 16'(irq_o), 16'h0);
    wr(A_MASK, 16'h007e);
    pulse(7'h03);
    rd_chk(A_VEC, 16'd2, "R6 masked skipped");
    rd_chk(A_VEC, 16'd0, "R6 masked not reported");
    rd_chk(A_STAT, 16'h0001, "R6 masked flag kept");
    wr(A_STAT, 16'h0001);
  endtask

  task automatic t_rx;
    wr(A_MASK, 16'h007f);
    pulse(7'h08);
    rd_chk(A_VEC, 16'd4, "R6 rx code");
    rd_chk(A_VEC, 16'd4, "R7 rx kept on read");
    cyc(8'h00, 0, 0, '0, '0, 1, 0);
    rd_chk(A_VEC, 16'd0, "R8 rx access clears");
  endtask

  task automatic t_collide;
    pulse(7'h02);
    cyc(A_STAT, 1, 0, 16'h0002, 7'h02, 0, 0);
    rd_chk(A_STAT, 16'h0002, "R9 event beats w1c");
    cyc(A_VEC, 0, 1, '0, 7'h02, 0, 0);
    chk("R9 vec code", rdata_o, 16'd2);
    rd_chk(A_STAT, 16'h0002, "R9 event beats read clear");
    pulse(7'h08);
    cyc(8'h00, 0, 0, '0, 7'h08, 1, 0);
    rd_chk(A_STAT, 16'h000a, "R9 event beats rx access");
    wr(A_STAT, 16'h007f);
  endtask

  task automatic t_unmapped;
    wr(A_NONE, 16'hffff);
    rd_chk(A_MASK, 16'h007f, "R11 write ignored");
    rd_chk(A_STAT, 16'h0000, "R11 status untouched");
    rd_chk(A_NONE, 16'h0000, "R11 unmapped reads 0");
    rd_chk(A_MASK, 16'h007f, "R11 latency");
    repeat (3) @(posedge clk_i);
    #1 chk("R11 rdata held", rdata_o, 16'h007f);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_status();
    t_w1c();
    t_mask();
    t_prio();
    t_rx();
    t_collide();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule